// File: doc/BRIEF.md
# Multiprocessor-Aware Serial Character Receiver

This block rebuilds characters from an asynchronous serial line. The line is sampled on a 16x oversampling tick. The character format is set by static mode inputs: 5 to 8 data bits sent least significant bit first, an optional parity bit of one of four kinds, an optional extra bit, and a short or long stop period. Each received character is presented right-justified together with its extra bit. A receive flag is raised and stays up until software acknowledges it.

For multi-drop links, the receiver can take part in address filtering. When multiprocessor filtering is on, a character is accepted only if its stop bit and its extra bit are both 1. Any other character is dropped silently, so software is woken only by address characters. Parity, framing and overrun problems are kept in sticky flags. One clear pulse acknowledges the character and all three flags together.

Top module: `uart_mp_rx`

## Requirements
- R1: `lenCode` 00/01/10/11 selects 5/6/7/8 data bits, received least significant bit first; `rxData` holds them right-justified with every unused upper bit at 0.
- R2: A high-to-low change of `rxIn` seen between two consecutive ticks begins a character, and the line is sampled again 8 ticks later; if that sample is high the receiver returns to idle and no output changes.
- R3: With `parityEn` = 1, a parity bit follows the data bits; `parityType` 00 = odd, 01 = even, 10 = always 1, 11 = always 0. A mismatch on an accepted character sets sticky `parityErr`, and the data is still delivered.
- R4: With `extraEn` = 1, one extra bit follows the parity bit (or the data bits when parity is off) and is placed on `rxExtra` for each accepted character; with `extraEn` = 0, `rxExtra` takes 0.
- R5: With `mpEnable` = 0, a character whose first stop bit is 1 is accepted: `rxData` and `rxExtra` are updated and `rxFlag` is set.
- R6: With `mpEnable` = 1, a character is accepted only when its first stop bit and its extra bit are both 1; any other character leaves `rxData`, `rxExtra`, `rxFlag` and `parityErr` unchanged.
- R7: A 0 on the first stop bit sets sticky `frameErr` and the character is not accepted.
- R8: Each bit is sampled 16 ticks after the previous one. With `longStop` = 0 the character completes on the first stop-bit sample. With `longStop` = 1 it completes 16 ticks later when there are 6 to 8 data bits, or 8 ticks later when there are 5.
- R9: `rxFlag` stays set until a one-cycle pulse on `rxFlagClr`, which clears `rxFlag`, `parityErr`, `frameErr` and `overrun`.
- R10: An accepted character that completes while `rxFlag` is still set overwrites `rxData` and sets sticky `overrun`.
- R11: After reset every output is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| lenCode | input | 2 | Data length select |
| parityEn | input | 1 | Parity bit present and checked |
| parityType | input | 2 | Parity kind select |
| extraEn | input | 1 | Extra bit present after data/parity |
| longStop | input | 1 | Long stop period |
| mpEnable | input | 1 | Multiprocessor address filtering |
| baudTick | input | 1 | One-cycle pulse at 16x the bit rate |
| rxIn | input | 1 | Serial line, idle high |
| rxFlagClr | input | 1 | Acknowledge pulse for flag and errors |
| rxData | output | 8 | Received character, right-justified |
| rxExtra | output | 1 | Extra bit of the last accepted character |
| rxFlag | output | 1 | Character received |
| parityErr | output | 1 | Sticky parity mismatch |
| frameErr | output | 1 | Sticky framing error |
| overrun | output | 1 | Sticky overwrite of an unacknowledged character |

## Verification
A bit counter or tick counter that slips moves every later sample point. This shows up within one character as shifted data bits, a wrong parity verdict or a false framing error, and it shows up at the exact tick where `rxFlag` rises. The bench therefore checks flag timing tick by tick at the end of the stop period for all three stop lengths. A state machine that fails to return to idle after a rejected start bit, or after a filtered address character, would swallow or corrupt the next character. For this reason, directed cases are always followed by a character whose contents are known.

// File: rtl/uart_rx_pkg.sv
package uart_rx_pkg;
  localparam int MAX_BITS = 8;

  typedef enum logic [2:0] {
    ST_IDLE, ST_START, ST_DATA, ST_PARITY, ST_EXTRA, ST_STOP, ST_HOLD
  } rxState_t;

  // strobes from control to datapath, each one clock wide on a tick
  typedef struct packed {
    logic startClr;
    logic dataBit;
    logic parityBit;
    logic extraBit;
    logic stopBit;
    logic frameDone;
  } rxStrobe_t;
endpackage

// File: rtl/rx_ctrl.sv
module rx_ctrl
  import uart_rx_pkg::*;
#(
  parameter int TICKS_PER_BIT = 16
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic [1:0] lenCode,
  input  logic       parityEn,
  input  logic       extraEn,
  input  logic       longStop,
  input  logic       baudTick,
  input  logic       rxIn,
  output rxStrobe_t  strobe
);
  localparam int CNT_W = $clog2(TICKS_PER_BIT);
  localparam logic [CNT_W-1:0] HALF_LAST = CNT_W'(TICKS_PER_BIT / 2 - 1);
  localparam logic [CNT_W-1:0] FULL_LAST = CNT_W'(TICKS_PER_BIT - 1);

  rxState_t state, stNext, afterData;
  logic [CNT_W-1:0] tickCnt;
  logic [2:0] bitIdx, lastIdx;
  logic lastRx, halfWindow, midHit;

  assign lastIdx    = 3'd4 + {1'b0, lenCode};
  assign halfWindow = (state == ST_START) ||
                      (state == ST_HOLD && lenCode == 2'b00);
  assign midHit     = baudTick && (tickCnt == (halfWindow ? HALF_LAST : FULL_LAST));
  assign afterData  = parityEn ? ST_PARITY : (extraEn ? ST_EXTRA : ST_STOP);

  always_comb begin
    stNext = state;
    strobe = '0;
    if (baudTick) begin
      case (state)
        ST_IDLE:   if (lastRx && !rxIn) stNext = ST_START;
        ST_START:  if (midHit) begin
                     if (rxIn) stNext = ST_IDLE;
                     else begin
                       stNext = ST_DATA;
                       strobe.startClr = 1'b1;
                     end
                   end
        ST_DATA:   if (midHit) begin
                     strobe.dataBit = 1'b1;
                     if (bitIdx == lastIdx) stNext = afterData;
                   end
        ST_PARITY: if (midHit) begin
                     strobe.parityBit = 1'b1;
                     stNext = extraEn ? ST_EXTRA : ST_STOP;
                   end
        ST_EXTRA:  if (midHit) begin
                     strobe.extraBit = 1'b1;
                     stNext = ST_STOP;
                   end
        ST_STOP:   if (midHit) begin
                     strobe.stopBit = 1'b1;
                     if (longStop) stNext = ST_HOLD;
                     else begin
                       strobe.frameDone = 1'b1;
                       stNext = ST_IDLE;
                     end
                   end
        ST_HOLD:   if (midHit) begin
                     strobe.frameDone = 1'b1;
                     stNext = ST_IDLE;
                   end
        default:   stNext = ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state   <= ST_IDLE;
      tickCnt <= '0;
      bitIdx  <= '0;
      lastRx  <= 1'b1;
    end else if (baudTick) begin
      lastRx <= rxIn;
      state  <= stNext;
      if (state == ST_IDLE || midHit) tickCnt <= '0;
      else tickCnt <= tickCnt + 1'b1;
      if (strobe.startClr) bitIdx <= '0;
      else if (strobe.dataBit) bitIdx <= bitIdx + 3'd1;
    end
  end

  // R8: the bit timer only advances on a tick
  assert_timer_holds_R8: assert property (@(posedge clk) disable iff (!rstN)
    !baudTick |=> $stable(tickCnt));

  // R1: exactly the configured number of data bits precede the stop sample
  assert_data_count_R1: assert property (@(posedge clk) disable iff (!rstN)
    strobe.stopBit |-> bitIdx == 3'(lastIdx + 3'd1));
endmodule

// File: rtl/rx_datapath.sv
module rx_datapath
  import uart_rx_pkg::*;
(
  input  logic                clk,
  input  logic                rstN,
  input  logic [1:0]          lenCode,
  input  logic                parityEn,
  input  logic [1:0]          parityType,
  input  logic                extraEn,
  input  logic                mpEnable,
  input  rxStrobe_t           strobe,
  input  logic                rxIn,
  input  logic                rxFlagClr,
  output logic [MAX_BITS-1:0] rxData,
  output logic                rxExtra,
  output logic                rxFlag,
  output logic                parityErr,
  output logic                frameErr,
  output logic                overrun
);
  logic [MAX_BITS-1:0] shiftReg, aligned;
  logic [3:0] dataBits, alignShift;
  logic parAcc, parRx, extraRx, stopRx;
  logic stopOk, extraVal, accept, expectPar, parBad;

  assign dataBits   = 4'd5 + {2'b00, lenCode};
  assign alignShift = 4'(MAX_BITS) - dataBits;
  assign aligned    = shiftReg >> alignShift;
  assign stopOk     = strobe.stopBit ? rxIn : stopRx;
  assign extraVal   = extraEn & extraRx;
  assign accept     = strobe.frameDone && stopOk && (!mpEnable || extraVal);
  assign parBad     = parityEn && (parRx != expectPar);

  always_comb begin
    case (parityType)
      2'b00:   expectPar = ~parAcc;
      2'b01:   expectPar = parAcc;
      2'b10:   expectPar = 1'b1;
      default: expectPar = 1'b0;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      shiftReg <= '0;
      parAcc   <= 1'b0;
      parRx    <= 1'b0;
      extraRx  <= 1'b0;
      stopRx   <= 1'b0;
    end else begin
      if (strobe.startClr) begin
        shiftReg <= '0;
        parAcc   <= 1'b0;
        extraRx  <= 1'b0;
      end
      if (strobe.dataBit) begin
        shiftReg <= {rxIn, shiftReg[MAX_BITS-1:1]};
        parAcc   <= parAcc ^ rxIn;
      end
      if (strobe.parityBit) parRx   <= rxIn;
      if (strobe.extraBit)  extraRx <= rxIn;
      if (strobe.stopBit)   stopRx  <= rxIn;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rxData    <= '0;
      rxExtra   <= 1'b0;
      rxFlag    <= 1'b0;
      parityErr <= 1'b0;
      frameErr  <= 1'b0;
      overrun   <= 1'b0;
    end else begin
      if (rxFlagClr) begin
        rxFlag    <= 1'b0;
        parityErr <= 1'b0;
        frameErr  <= 1'b0;
        overrun   <= 1'b0;
      end
      if (strobe.frameDone && !stopOk) frameErr <= 1'b1;
      if (accept) begin
        rxData  <= aligned;
        rxExtra <= extraVal;
        rxFlag  <= 1'b1;
        if (rxFlag && !rxFlagClr) overrun <= 1'b1;
        if (parBad) parityErr <= 1'b1;
      end
    end
  end

  // R5: the flag only rises on a character completion from control
  assert_flag_on_done_R5: assert property (@(posedge clk) disable iff (!rstN)
    $rose(rxFlag) |-> $past(strobe.frameDone));

  // R10: overrun only rises while a character was pending
  assert_overrun_pending_R10: assert property (@(posedge clk) disable iff (!rstN)
    $rose(overrun) |-> $past(rxFlag));

  // R6: in filtering mode an accepted character carries extra bit 1
  assert_mp_address_R6: assert property (@(posedge clk) disable iff (!rstN)
    ($rose(rxFlag) && mpEnable) |-> rxExtra);

  // R1: bits above the configured length read as zero
  assert_right_justified_R1: assert property (@(posedge clk) disable iff (!rstN)
    $rose(rxFlag) |-> (rxData >> dataBits) == '0);

  // R7: a framing error never comes with a new character
  assert_frame_no_accept_R7: assert property (@(posedge clk) disable iff (!rstN)
    $rose(frameErr) |-> !$rose(rxFlag));
endmodule

// File: rtl/uart_mp_rx.sv
module uart_mp_rx
  import uart_rx_pkg::*;
#(
  parameter int TICKS_PER_BIT = 16
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic [1:0] lenCode,
  input  logic       parityEn,
  input  logic [1:0] parityType,
  input  logic       extraEn,
  input  logic       longStop,
  input  logic       mpEnable,
  input  logic       baudTick,
  input  logic       rxIn,
  input  logic       rxFlagClr,
  output logic [7:0] rxData,
  output logic       rxExtra,
  output logic       rxFlag,
  output logic       parityErr,
  output logic       frameErr,
  output logic       overrun
);
  rxStrobe_t strobe;

  rx_ctrl #(.TICKS_PER_BIT(TICKS_PER_BIT)) u_ctrl (
    .clk(clk), .rstN(rstN), .lenCode(lenCode), .parityEn(parityEn),
    .extraEn(extraEn), .longStop(longStop), .baudTick(baudTick),
    .rxIn(rxIn), .strobe(strobe)
  );

  rx_datapath u_dp (
    .clk(clk), .rstN(rstN), .lenCode(lenCode), .parityEn(parityEn),
    .parityType(parityType), .extraEn(extraEn), .mpEnable(mpEnable),
    .strobe(strobe), .rxIn(rxIn), .rxFlagClr(rxFlagClr),
    .rxData(rxData), .rxExtra(rxExtra), .rxFlag(rxFlag),
    .parityErr(parityErr), .frameErr(frameErr), .overrun(overrun)
  );
endmodule

// File: tb/uart_mp_rx_tb.sv
module uart_mp_rx_tb;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [1:0] lenCode = 2'b11;
  logic parityEn = 1'b0;
  logic [1:0] parityType = 2'b00;
  logic extraEn = 1'b0, longStop = 1'b0, mpEnable = 1'b0;
  logic baudTick = 1'b0, rxIn = 1'b1, rxFlagClr = 1'b0;
  logic [7:0] rxData;
  logic rxExtra, rxFlag, parityErr, frameErr, overrun;

  int nChecks = 0, nErrors = 0, tickDiv = 0;
  logic [7:0] expData = '0;
  logic expExtra = 0, expFlag = 0, expPar = 0, expFrm = 0, expOvr = 0;

  always #5 clk = ~clk;

  always @(negedge clk) begin
    tickDiv  = (tickDiv + 1) % 4;
    baudTick = (tickDiv == 0);
  end

  uart_mp_rx u_dut (
    .clk(clk), .rstN(rstN), .lenCode(lenCode), .parityEn(parityEn),
    .parityType(parityType), .extraEn(extraEn), .longStop(longStop),
    .mpEnable(mpEnable), .baudTick(baudTick), .rxIn(rxIn),
    .rxFlagClr(rxFlagClr), .rxData(rxData), .rxExtra(rxExtra),
    .rxFlag(rxFlag), .parityErr(parityErr), .frameErr(frameErr),
    .overrun(overrun)
  );

  task automatic chk(input string tag, input int act, input int exp);
    nChecks++;
    if (act != exp) begin
      nErrors++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic waitTicks(input int n);
    repeat (n) @(posedge clk iff baudTick);
    @(negedge clk);
  endtask

  task automatic driveBit(input logic v);
    rxIn = v;
    waitTicks(16);
  endtask

  function automatic logic parBit(input logic [7:0] d, input int n, input logic [1:0] t);
    logic ones = ^(d & 8'((1 << n) - 1));
    case (t)
      2'b00:   return ~ones;
      2'b01:   return ones;
      2'b10:   return 1'b1;
      default: return 1'b0;
    endcase
  endfunction

  task automatic sendFrame(input logic [7:0] d, input logic badPar,
                           input logic xb, input logic stopV);
    int n = 5 + int'(lenCode);
    driveBit(1'b0);
    for (int i = 0; i < n; i++) driveBit(d[i]);
    if (parityEn) driveBit(parBit(d, n, parityType) ^ badPar);
    if (extraEn) driveBit(xb);
    driveBit(stopV);
    rxIn = 1'b1;
  endtask

  function automatic void applyModel(input logic [7:0] d, input logic badPar,
                                     input logic xb, input logic stopV);
    int n = 5 + int'(lenCode);
    logic acc = stopV && (!mpEnable || (extraEn && xb));
    if (!stopV) expFrm = 1'b1;
    if (acc) begin
      if (expFlag) expOvr = 1'b1;
      expFlag  = 1'b1;
      expData  = d & 8'((1 << n) - 1);
      expExtra = extraEn & xb;
      if (parityEn && badPar) expPar = 1'b1;
    end
  endfunction

  task automatic checkAll();
    chk("R1 rxData", rxData, expData);
    chk("R4 rxExtra", rxExtra, expExtra);
    chk(mpEnable ? "R6 rxFlag" : "R5 rxFlag", rxFlag, expFlag);
    chk("R3 parityErr", parityErr, expPar);
    chk("R7 frameErr", frameErr, expFrm);
    chk("R10 overrun", overrun, expOvr);
  endtask

  task automatic clearFlags();
    rxFlagClr = 1'b1;
    @(negedge clk);
    rxFlagClr = 1'b0;
    expFlag = 0; expPar = 0; expFrm = 0; expOvr = 0;
  endtask

  task automatic fullFrame(input logic [7:0] d, input logic badPar,
                           input logic xb, input logic stopV);
    sendFrame(d, badPar, xb, stopV);
    waitTicks(20);
    applyModel(d, badPar, xb, stopV);
    checkAll();
  endtask

  task automatic stopTiming(input logic [1:0] len, input logic lng);
    lenCode = len; longStop = lng; parityEn = 0; extraEn = 0; mpEnable = 0;
    clearFlags();
    sendFrame(8'hA5, 0, 0, 1);
    chk("R8 flag at end of first stop", rxFlag, !lng);
    waitTicks(1);
    chk("R8 flag one tick later", rxFlag, !(lng && len != 2'b00));
    waitTicks(8);
    chk("R8 flag nine ticks later", rxFlag, 1);
    waitTicks(20);
    applyModel(8'hA5, 0, 0, 1);
    checkAll();
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    nErrors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", nChecks, nErrors);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    repeat (5) @(negedge clk);
    chk("R11 reset outputs", {rxData, rxExtra, rxFlag, parityErr, frameErr, overrun}, 0);
    rstN = 1'b1;
    waitTicks(4);
    chk("R11 outputs after release", {rxData, rxExtra, rxFlag, parityErr, frameErr, overrun}, 0);

    // R2: a low glitch shorter than half a bit is not a start bit
    rxIn = 1'b0;
    waitTicks(4);
    rxIn = 1'b1;
    waitTicks(40);
    chk("R2 false start flag", rxFlag, 0);
    chk("R2 false start frameErr", frameErr, 0);
    chk("R2 false start data", rxData, 0);
    fullFrame(8'h3C, 0, 0, 1);

    // R8: completion tick for short, 2-stop and 1.5-stop periods
    stopTiming(2'b11, 0);
    stopTiming(2'b11, 1);
    stopTiming(2'b00, 1);
    stopTiming(2'b01, 1);

    // R6: address filtering
    lenCode = 2'b11; longStop = 0; extraEn = 1; mpEnable = 1; parityEn = 0;
    clearFlags();
    fullFrame(8'h5A, 0, 0, 1);
    chk("R6 data frame filtered", rxFlag, 0);
    fullFrame(8'h96, 0, 1, 1);
    chk("R6 address frame accepted", rxData, 8'h96);

    // R7: bad stop bit, then R9 clear
    mpEnable = 0; extraEn = 0;
    fullFrame(8'hFF, 0, 0, 0);
    chk("R7 data kept on framing error", rxData, 8'h96);

    // R10: second character without acknowledge
    fullFrame(8'h11, 0, 0, 1);
    fullFrame(8'h22, 0, 0, 1);
    chk("R10 overrun set", overrun, 1);
    clearFlags();
    chk("R9 flag cleared", rxFlag, 0);
    chk("R9 errors cleared", {parityErr, frameErr, overrun}, 0);

    // R3: each parity kind with a corrupted bit, on 7 data bits
    lenCode = 2'b10; parityEn = 1;
    for (int t = 0; t < 4; t++) begin
      parityType = 2'(t);
      clearFlags();
      fullFrame(8'h6B, 0, 0, 1);
      chk("R3 good parity", parityErr, 0);
      fullFrame(8'h6B, 1, 0, 1);
      chk("R3 bad parity delivered", rxData, 8'h6B);
    end

    // random characters in random formats
    for (int k = 0; k < 40; k++) begin
      logic [7:0] d = 8'($urandom);
      logic badPar, xb, stopV;
      lenCode    = 2'($urandom);
      parityEn   = 1'($urandom);
      parityType = 2'($urandom);
      extraEn    = 1'($urandom);
      longStop   = 1'($urandom);
      mpEnable   = extraEn && ($urandom % 3 == 0);
      badPar     = parityEn && ($urandom % 5 == 0);
      xb         = 1'($urandom);
      stopV      = ($urandom % 8 != 0);
      if ($urandom % 2 == 0) clearFlags();
      fullFrame(d, badPar, xb, stopV);
    end

    $display("Simulation finished: %0d checks, %0d errors", nChecks, nErrors);
    $finish;
  end
endmodule